// File: doc/BRIEF.md
# Buffer-Occupancy Class Pause Generator

This block turns the free-block count of a shared receive buffer into per-class pause requests for a MAC. Two requests are tracked: one for high-priority traffic and one for low-priority traffic. Each request has its own pair of watermarks, which gives it hysteresis. The request turns on when free space falls under its lower watermark. It turns off only once free space climbs past its upper watermark.

Each request is then spread across a 16-bit class vector through a software-written class mask. Two external requesters can also contribute class bits, each gated by a source-enable pin.

Software selects one of three pause modes: link-wide pause, per-class, or per-priority. The block refuses any write that would leave more than one mode enabled. The registered class vector goes to the MAC. A one-cycle strobe marks each change of the vector while the output enable is set.

Top module: `fc_class_pause_gen`

## Requirements
- R1: After reset, `pause_vec` and `pause_valid` are 0, all watermarks and masks are 0, and every enable is off.
- R2: A request sets when `free_blocks` is strictly less than its lower watermark. A count equal to the lower watermark does not set it. A change of `free_blocks` reaches `pause_vec` two clock edges later.
- R3: A set request clears only when `free_blocks` is strictly greater than its upper watermark. For any count from the lower watermark up to and including the upper one, the request keeps its previous value.
- R4: The high-priority request uses the watermarks at addresses 0 (lower) and 1 (upper). The low-priority request uses addresses 2 (lower) and 3 (upper). The two requests act independently.
- R5: In per-class or per-priority mode, the class vector is the OR of three parts:
  - the high mask (address 4) ANDed with the high request and the low mask (address 5) ANDed with the low request, included only when `src_en[0]` is 1;
  - `ext_req_a`, included only when `src_en[1]` is 1;
  - `ext_req_b`, included only when `src_en[2]` is 1.
- R6: The mode enables are written through bit 0 of separate registers: link pause at address 8, per-class at address 9, per-priority at address 10. A write that sets one enable while another is already set is ignored, and the stored enable values stay as they were. Writing 0 is always accepted.
- R7: `pause_valid` pulses for exactly one cycle, in the same cycle that `pause_vec` takes a new value, but only when the output enable (address 11, bit 0) is 1. While the output enable is 0, no pulse is issued.
- R8: In link pause mode, bit 0 of `pause_vec` is the OR of all class bits, and bits 15..1 are 0.
- R9: With no mode enabled, `pause_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_blocks | input | 10 | Current free-block count of the receive buffer |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| src_en | input | 3 | Source gates: bit 0 occupancy logic, bit 1 requester A, bit 2 requester B |
| ext_req_a | input | 16 | Class requests from external requester A |
| ext_req_b | input | 16 | Class requests from external requester B |
| pause_vec | output | 16 | Registered per-class pause vector toward the MAC |
| pause_valid | output | 1 | One-cycle strobe marking a new vector |

## Verification
The hardest cases to reach are the rejected mode writes. Their effect is visible only indirectly, through the shape of the vector. The stimulus first sets up a steady per-class pattern with both requests raised. It then tries to enable link pause and per-priority on top of per-class, and checks that the vector does not collapse to bit 0. The same check runs in the opposite direction, trying to enable per-class while link pause is on.

The hysteresis band is covered by walking the count onto each watermark exactly and one step past it. A strobe counter checks that each change of the vector produces exactly one pulse.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_HI_LOWER  = 4'd0,
        A_HI_UPPER  = 4'd1,
        A_LO_LOWER  = 4'd2,
        A_LO_UPPER  = 4'd3,
        A_MASK_HI   = 4'd4,
        A_MASK_LO   = 4'd5,
        A_LINK_EN   = 4'd8,
        A_CLASS_EN  = 4'd9,
        A_PRIO_EN   = 4'd10,
        A_OUT_EN    = 4'd11
    } fcg_addr_e;

    localparam int N_REQ = 2;   // index 0: high priority, 1: low priority
    localparam int N_EXT = 2;
    localparam int N_SRC = 1 + N_EXT;

    typedef struct packed {
        logic link;
        logic cls;
        logic prio;
    } fcg_mode_t;
endpackage

// File: rtl/fcg_cfg.sv
module fcg_cfg
    import fcg_pkg::*;
#(
    parameter int THR_W  = 10,
    parameter int CLS_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [N_REQ-1:0][THR_W-1:0]  thr_lower,
    output logic [N_REQ-1:0][THR_W-1:0]  thr_upper,
    output logic [N_REQ-1:0][CLS_W-1:0]  cls_mask,
    output fcg_mode_t                    mode,
    output logic                         out_en
);
    typedef struct packed {
        logic [N_REQ-1:0][THR_W-1:0] lower;
        logic [N_REQ-1:0][THR_W-1:0] upper;
        logic [N_REQ-1:0][CLS_W-1:0] mask;
        fcg_mode_t                   mode;
        logic                        oen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (fcg_addr_e'(addr))
                A_HI_LOWER: cfg_d.lower[0] = wdata[THR_W-1:0];
                A_HI_UPPER: cfg_d.upper[0] = wdata[THR_W-1:0];
                A_LO_LOWER: cfg_d.lower[1] = wdata[THR_W-1:0];
                A_LO_UPPER: cfg_d.upper[1] = wdata[THR_W-1:0];
                A_MASK_HI:  cfg_d.mask[0]  = wdata[CLS_W-1:0];
                A_MASK_LO:  cfg_d.mask[1]  = wdata[CLS_W-1:0];
                A_LINK_EN:
                    if (!wdata[0] || (!cfg_q.mode.cls && !cfg_q.mode.prio))
                        cfg_d.mode.link = wdata[0];
                A_CLASS_EN:
                    if (!wdata[0] || (!cfg_q.mode.link && !cfg_q.mode.prio))
                        cfg_d.mode.cls = wdata[0];
                A_PRIO_EN:
                    if (!wdata[0] || (!cfg_q.mode.link && !cfg_q.mode.cls))
                        cfg_d.mode.prio = wdata[0];
                A_OUT_EN:   cfg_d.oen = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign thr_lower = cfg_q.lower;
    assign thr_upper = cfg_q.upper;
    assign cls_mask  = cfg_q.mask;
    assign mode      = cfg_q.mode;
    assign out_en    = cfg_q.oen;
endmodule

// File: rtl/fcg_hyst.sv
module fcg_hyst #(
    parameter int THR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] level,
    input  logic [THR_W-1:0] lower,
    input  logic [THR_W-1:0] upper,
    output logic             req
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (level < lower)      req_d = 1'b1;
        else if (level > upper) req_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;
endmodule

// File: rtl/fcg_map.sv
module fcg_map
    import fcg_pkg::*;
#(
    parameter int CLS_W = 16
) (
    input  logic [N_REQ-1:0]             req,
    input  logic [N_REQ-1:0][CLS_W-1:0]  cls_mask,
    input  logic [N_SRC-1:0]             src_en,
    input  logic [N_EXT-1:0][CLS_W-1:0]  ext_req,
    input  fcg_mode_t                    mode,
    output logic [CLS_W-1:0]             vec
);
    logic [N_REQ-1:0][CLS_W-1:0] req_part;
    logic [N_EXT-1:0][CLS_W-1:0] ext_part;
    logic [CLS_W-1:0]            own_vec;
    logic [CLS_W-1:0]            ext_vec;
    logic [CLS_W-1:0]            cls_vec;

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        assign req_part[g] = cls_mask[g] & {CLS_W{req[g]}};
    end
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign ext_part[g] = ext_req[g] & {CLS_W{src_en[g+1]}};
    end

    always_comb begin
        own_vec = '0;
        for (int i = 0; i < N_REQ; i++) own_vec |= req_part[i];
        ext_vec = '0;
        for (int i = 0; i < N_EXT; i++) ext_vec |= ext_part[i];
        cls_vec = (src_en[0] ? own_vec : '0) | ext_vec;
        vec = '0;
        if (mode.cls || mode.prio) vec = cls_vec;
        else if (mode.link)        vec[0] = |cls_vec;
    end
endmodule

// File: rtl/fc_class_pause_gen.sv
module fc_class_pause_gen
    import fcg_pkg::*;
#(
    parameter int THR_W  = 10,
    parameter int CLS_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  free_blocks,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [2:0]        src_en,
    input  logic [CLS_W-1:0]  ext_req_a,
    input  logic [CLS_W-1:0]  ext_req_b,
    output logic [CLS_W-1:0]  pause_vec,
    output logic              pause_valid
);
    typedef struct packed {
        logic [CLS_W-1:0] vec;
        logic             vld;
    } out_t;

    logic [N_REQ-1:0][THR_W-1:0] thr_lower, thr_upper;
    logic [N_REQ-1:0][CLS_W-1:0] cls_mask;
    fcg_mode_t                   mode;
    logic                        out_en;
    logic [N_REQ-1:0]            req;
    logic [N_EXT-1:0][CLS_W-1:0] ext_req;
    logic [CLS_W-1:0]            map_vec;
    out_t                        out_d, out_q;

    fcg_cfg #(.THR_W(THR_W), .CLS_W(CLS_W), .DATA_W(DATA_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .thr_lower(thr_lower), .thr_upper(thr_upper),
        .cls_mask(cls_mask), .mode(mode), .out_en(out_en)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_hyst
        fcg_hyst #(.THR_W(THR_W)) i_hyst (
            .clk(clk), .rst_n(rst_n), .level(free_blocks),
            .lower(thr_lower[g]), .upper(thr_upper[g]), .req(req[g])
        );
    end

    assign ext_req[0] = ext_req_a;
    assign ext_req[1] = ext_req_b;

    fcg_map #(.CLS_W(CLS_W)) i_map (
        .req(req), .cls_mask(cls_mask), .src_en(src_en),
        .ext_req(ext_req), .mode(mode), .vec(map_vec)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vec = map_vec;
        out_d.vld = out_en && (map_vec != out_q.vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pause_vec   = out_q.vec;
    assign pause_valid = out_q.vld;
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker
    import fcg_pkg::*;
#(
    parameter int THR_W = 10,
    parameter int CLS_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [THR_W-1:0]             free_blocks,
    input logic [N_REQ-1:0][THR_W-1:0]  thr_lower,
    input logic [N_REQ-1:0][THR_W-1:0]  thr_upper,
    input logic [N_REQ-1:0]             req,
    input fcg_mode_t                    mode,
    input logic                         out_en,
    input logic [CLS_W-1:0]             pause_vec,
    input logic                         pause_valid
);
    // R2: below the lower watermark the high request is set next cycle
    p_set_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_blocks < thr_lower[0]) |=> req[0]);

    // R3: inside the band with stable watermarks the low request holds
    p_hold_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_blocks >= thr_lower[1] && free_blocks <= thr_upper[1]
         && $stable(thr_lower[1]) && $stable(thr_upper[1])) |=> $stable(req[1]));

    // R6: never more than one pause mode enabled
    p_mode_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode.link, mode.cls, mode.prio}) <= 1);

    // R7: a strobe always accompanies a new vector and an enabled output
    p_valid_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid |-> (pause_vec != $past(pause_vec)) && $past(out_en));

    // R8: link pause mode drives only bit 0
    p_link_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.link && !mode.cls && !mode.prio) |=> (pause_vec[CLS_W-1:1] == '0));

    // R9: with all modes off the vector goes to zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.link && !mode.cls && !mode.prio) |=> (pause_vec == '0));
endmodule

bind fc_class_pause_gen fcg_checker #(.THR_W(THR_W), .CLS_W(CLS_W)) i_fcg_checker (
    .clk(clk), .rst_n(rst_n), .free_blocks(free_blocks),
    .thr_lower(thr_lower), .thr_upper(thr_upper), .req(req),
    .mode(mode), .out_en(out_en), .pause_vec(pause_vec),
    .pause_valid(pause_valid)
);

// File: tb/test_fc_class_pause_gen.sv
module test_fc_class_pause_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  free_blocks = 10'd1000;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  src_en = '0;
    logic [15:0] ext_req_a = '0;
    logic [15:0] ext_req_b = '0;
    logic [15:0] pause_vec;
    logic        pause_valid;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fc_class_pause_gen i_fc_class_pause_gen (
        .clk(clk), .rst_n(rst_n), .free_blocks(free_blocks),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .src_en(src_en), .ext_req_a(ext_req_a), .ext_req_b(ext_req_b),
        .pause_vec(pause_vec), .pause_valid(pause_valid)
    );

    always @(negedge clk) if (pause_valid) strobes++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_free(input logic [9:0] v);
        @(negedge clk);
        free_blocks = v;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 vec", pause_vec, 0);
        chk("R1 valid", pause_valid, 0);
        free_blocks = 10'd0;
        src_en = 3'b111;
        ext_req_a = 16'hFFFF;
        settle();
        chk("R1 no mode after reset", pause_vec, 0);
        ext_req_a = 16'h0;
        free_blocks = 10'd1000;
        settle();
    endtask

    task automatic t_config();
        wr(4'd0, 16'd100); wr(4'd1, 16'd200);
        wr(4'd2, 16'd300); wr(4'd3, 16'd400);
        wr(4'd4, 16'h00F0); wr(4'd5, 16'h000F);
        wr(4'd9, 16'd1); wr(4'd11, 16'd1);
        src_en = 3'b001;
        settle();
        chk("R5 idle", pause_vec, 0);
    endtask

    task automatic t_hysteresis();
        strobes = 0;
        set_free(10'd300); chk("R2 equal lower no set", pause_vec, 16'h0000);
        // R2 latency: two edges after the change
        @(negedge clk); free_blocks = 10'd299;
        @(negedge clk); chk("R2 not yet after one edge", pause_vec, 16'h0000);
        @(negedge clk); chk("R2 low set", pause_vec, 16'h000F);
        set_free(10'd400); chk("R3 equal upper holds", pause_vec, 16'h000F);
        set_free(10'd150); chk("R4 high independent", pause_vec, 16'h000F);
        set_free(10'd99);  chk("R4 high set", pause_vec, 16'h00FF);
        set_free(10'd200); chk("R3 high holds at upper", pause_vec, 16'h00FF);
        set_free(10'd201); chk("R3 high clears", pause_vec, 16'h000F);
        set_free(10'd401); chk("R3 low clears", pause_vec, 16'h0000);
        chk("R7 strobe count", strobes, 4);
    endtask

    task automatic t_sources();
        ext_req_a = 16'h8000; ext_req_b = 16'h0100;
        src_en = 3'b011; settle();
        chk("R5 ext a", pause_vec, 16'h8000);
        src_en = 3'b101; settle();
        chk("R5 ext b", pause_vec, 16'h0100);
        ext_req_a = 0; ext_req_b = 0;
        src_en = 3'b000;
        set_free(10'd50);
        chk("R5 own gated", pause_vec, 16'h0000);
        src_en = 3'b001; settle();
        chk("R5 own on", pause_vec, 16'h00FF);
    endtask

    task automatic t_modes();
        wr(4'd8, 16'd1); settle();
        chk("R6 link rejected", pause_vec, 16'h00FF);
        wr(4'd10, 16'd1); settle();
        chk("R6 prio rejected", pause_vec, 16'h00FF);
        wr(4'd9, 16'd0); settle();
        chk("R9 no mode", pause_vec, 16'h0000);
        wr(4'd8, 16'd1); settle();
        chk("R8 link bit0", pause_vec, 16'h0001);
        wr(4'd9, 16'd1); settle();
        chk("R6 class rejected", pause_vec, 16'h0001);
        wr(4'd8, 16'd0); wr(4'd10, 16'd1); settle();
        chk("R6 prio accepted", pause_vec, 16'h00FF);
    endtask

    task automatic t_out_en();
        wr(4'd11, 16'd0);
        strobes = 0;
        set_free(10'd500);
        chk("R7 vec still tracks", pause_vec, 16'h0000);
        chk("R7 no strobe when disabled", strobes, 0);
        wr(4'd11, 16'd1);
        strobes = 0;
        set_free(10'd50);
        chk("R7 one strobe", strobes, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_hysteresis();
        t_sources();
        t_modes();
        t_out_en();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule